// File: doc/BRIEF.md
# Configurable Best-State Traceback Unit

This block runs the traceback pass of a Viterbi decoder whose constraint length K can be switched between 7, 8, 9 and 10. The survivor bits sit in an external 4096 x 8 memory with one synchronous read port, one trellis iteration per group of consecutive words. A best-state finder elsewhere supplies the starting coordinates with a one-cycle start pulse. The unit then walks the survivor path backwards. Each step spends one clock reading a survivor word and one clock working out the previous memory coordinates. After the requested depth it emits a short burst of decoded bits, oldest first, each marked with a valid strobe.

The predecessor is found directly on the packed coordinates. No state number is formed. A single pair of XOR gates, a shift of the cycle field and a decrement of the iteration field do the work, and the same logic serves every K. Decoded bits come out newest first during the walk. A small LIFO turns them back into time order.

Top module: `cfg_traceback_unit`

## Requirements
- R1: After reset, and with no start pulse, `dec_valid` and `mem_rd_en` stay low.
- R2: `k_sel` values 0, 1, 2 and 3 select K = 7, 8, 9 and 10, and are sampled together with `tb_depth` on an accepted start. A memory address is {I, C}: C is the low c = K-4 bits and I is the remaining high bits. The first survivor read uses exactly `start_addr`.
- R3: With m = K-1 state bits, the state s at position (C, R) is: s[m-1] = R[1], s[m-2] = R[2] xor C[c-1], s[m-3-j] = C[j] for j = 0..c-1, and s[0] = R[0]. The survivor bit V is bit R of word {I, C}. The predecessor is R' = {R[1] xor C[c-2], V, C[c-1]}, C' = {C[c-2:0], R[2] xor C[c-1]}, I' = I-1. Decoded bit values equal s[0] of the visited positions.
- R4: Each step takes two clocks, so `mem_rd_en` is never high on two consecutive cycles.
- R5: The iteration field decrements modulo 2^(12-c), so a walk may wrap through iteration 0.
- R6: A traceback with effective depth TB issues exactly TB + D - 1 survivor reads, where D = 16, 8, 4 and 2 for K = 7, 8, 9 and 10.
- R7: A requested depth above 49, 57, 61 or 62 (for K = 7, 8, 9, 10) is replaced by that maximum.
- R8: Exactly D decoded bits are output, one per `dec_valid` pulse. They are the s[0] bits of the positions reached after TB through TB+D-1 steps, delivered oldest first. No bit is output while reads are still being issued.
- R9: A start pulse that arrives while a traceback is in progress is ignored, together with the values on its coordinate and configuration inputs.
- R10: For K = 7, a start at I = 5, C = 100, R = 101 with survivor bit 1 reads address 0x02C first and address 0x020 (I = 4, C = 000) next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_sel | input | 2 | Constraint length select, K = 7 + k_sel |
| tb_depth | input | 6 | Requested traceback depth in steps |
| start | input | 1 | One-cycle start request |
| start_addr | input | 12 | Starting memory coordinates {I, C} |
| start_ridx | input | 3 | Starting bit index R within the survivor word |
| mem_rd_en | output | 1 | Survivor memory read strobe |
| mem_rd_addr | output | 12 | Survivor memory read address |
| mem_rd_data | input | 8 | Survivor word, valid the cycle after the read strobe |
| dec_bit | output | 1 | Decoded bit |
| dec_valid | output | 1 | Qualifies `dec_bit` |

## Verification
The bench encodes random bit streams for every K. It writes the true-path survivor bits into a model memory and fills all other words with noise. A unit that took a wrong XOR or a wrong shift would leave the true path and output noise. Directed cases cover a depth of zero, a walk that wraps the iteration field through zero, and depth requests above each K's limit. A missing clamp shows up as extra reads and shifted output bits. A restart request during a walk must not change the result, which catches a unit that reloads its coordinates in mid-walk. The worked K = 7 example pins the exact second read address, which catches a swapped bit order in the coordinate update.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

  localparam int unsigned SM_ADDR_W = 12;
  localparam int unsigned SM_DATA_W = 8;
  localparam int unsigned RIDX_W    = $clog2(SM_DATA_W);
  localparam int unsigned KSEL_W    = 2;
  localparam int unsigned DEPTH_W   = 6;
  localparam int unsigned CW_W      = 3;
  localparam int unsigned CW_MIN    = 3;
  localparam int unsigned DEC_MAX   = 16;
  localparam int unsigned DEC_W     = $clog2(DEC_MAX + 1);
  localparam int unsigned STEP_W    = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_UPD  = 2'd2,
    ST_EMIT = 2'd3
  } tbu_state_e;

  // width of the cycle field for a given constraint length select
  function automatic logic [CW_W-1:0] cw_of(input logic [KSEL_W-1:0] ks);
    return CW_W'(CW_MIN) + CW_W'(ks);
  endfunction

  // decoded bits produced by one traceback
  function automatic logic [DEC_W-1:0] dec_cnt_of(input logic [KSEL_W-1:0] ks);
    return DEC_W'(DEC_MAX) >> ks;
  endfunction

  function automatic logic [DEPTH_W-1:0] max_depth_of(input logic [KSEL_W-1:0] ks);
    logic [DEPTH_W-1:0] lim;
    case (ks)
      2'd0:    lim = DEPTH_W'(49);
      2'd1:    lim = DEPTH_W'(57);
      2'd2:    lim = DEPTH_W'(61);
      default: lim = DEPTH_W'(62);
    endcase
    return lim;
  endfunction

  function automatic logic [DEPTH_W-1:0] clamp_depth(input logic [DEPTH_W-1:0] req,
                                                     input logic [KSEL_W-1:0]  ks);
    logic [DEPTH_W-1:0] lim;
    lim = max_depth_of(ks);
    return (req > lim) ? lim : req;
  endfunction

  // previous {I, C}: cycle field shifts up with one XOR at the bottom, iteration decrements
  function automatic logic [SM_ADDR_W-1:0] step_addr(input logic [SM_ADDR_W-1:0] a,
                                                     input logic [RIDX_W-1:0]    r,
                                                     input logic [CW_W-1:0]      cw);
    logic [SM_ADDR_W-1:0] mask;
    logic [SM_ADDR_W-1:0] cfield;
    logic [SM_ADDR_W-1:0] ifield;
    logic [SM_ADDR_W-1:0] ncf;
    logic [CW_W-1:0]      hi_i;
    hi_i   = cw - CW_W'(1);
    mask   = (SM_ADDR_W'(1) << cw) - SM_ADDR_W'(1);
    cfield = a & mask;
    ifield = a >> cw;
    ncf    = ((cfield << 1) & mask) | SM_ADDR_W'(r[2] ^ a[hi_i]);
    return ((ifield - SM_ADDR_W'(1)) << cw) | ncf;
  endfunction

  // previous bit index: second XOR, the survivor bit, and the top cycle bit
  function automatic logic [RIDX_W-1:0] step_ridx(input logic [SM_ADDR_W-1:0] a,
                                                  input logic [RIDX_W-1:0]    r,
                                                  input logic                 v,
                                                  input logic [CW_W-1:0]      cw);
    logic [CW_W-1:0] hi_i;
    logic [CW_W-1:0] lo_i;
    hi_i = cw - CW_W'(1);
    lo_i = cw - CW_W'(2);
    return {r[1] ^ a[lo_i], v, a[hi_i]};
  endfunction

endpackage

// File: rtl/tbu_cfg_decode.sv
module tbu_cfg_decode
  import tbu_pkg::*;
#(
  parameter int unsigned KS_W  = KSEL_W,
  parameter int unsigned DP_W  = DEPTH_W,
  parameter int unsigned DC_W  = DEC_W,
  parameter int unsigned CWD_W = CW_W
) (
  input  logic [KS_W-1:0]  ks,
  input  logic [DP_W-1:0]  depth_req,
  output logic [DP_W-1:0]  depth_eff,
  output logic [DC_W-1:0]  dec_cnt,
  output logic [CWD_W-1:0] cw
);

  always_comb begin
    depth_eff = clamp_depth(depth_req, ks);
    dec_cnt   = dec_cnt_of(ks);
    cw        = cw_of(ks);
  end

endmodule

// File: rtl/tbu_step_unit.sv
module tbu_step_unit
  import tbu_pkg::*;
#(
  parameter int unsigned A_W = SM_ADDR_W,
  parameter int unsigned D_W = SM_DATA_W,
  parameter int unsigned R_W = RIDX_W,
  parameter int unsigned C_W = CW_W
) (
  input  logic [A_W-1:0] cur_addr,
  input  logic [R_W-1:0] cur_ridx,
  input  logic [D_W-1:0] word,
  input  logic [C_W-1:0] cw,
  output logic           surv_bit,
  output logic [A_W-1:0] nxt_addr,
  output logic [R_W-1:0] nxt_ridx
);

  always_comb begin
    surv_bit = word[cur_ridx];
    nxt_addr = step_addr(cur_addr, cur_ridx, cw);
    nxt_ridx = step_ridx(cur_addr, cur_ridx, surv_bit, cw);
  end

endmodule

// File: rtl/tbu_lifo.sv
module tbu_lifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             din,
  output logic             dout,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slots;
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] top_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[g] <= 1'b0;
      else if (push && (count_q == CNT_W'(g)))
        slots[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (push && !pop)
      count_q <= count_q + CNT_W'(1);
    else if (pop && !push)
      count_q <= count_q - CNT_W'(1);
  end

  assign top_idx = IDX_W'(count_q - CNT_W'(1));
  assign dout    = slots[top_idx];
  assign count   = count_q;

endmodule

// File: rtl/cfg_traceback_unit.sv
module cfg_traceback_unit
  import tbu_pkg::*;
#(
  parameter int unsigned ADDR_W  = SM_ADDR_W,
  parameter int unsigned DATA_W  = SM_DATA_W,
  parameter int unsigned KS_W    = KSEL_W,
  parameter int unsigned DP_W    = DEPTH_W,
  parameter int unsigned OUT_MAX = DEC_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KS_W-1:0]   k_sel,
  input  logic [DP_W-1:0]   tb_depth,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [RIDX_W-1:0] start_ridx,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              dec_bit,
  output logic              dec_valid
);

  localparam int unsigned LCNT_W = $clog2(OUT_MAX + 1);

  // configuration decoded from the live inputs, latched on an accepted start
  logic [DP_W-1:0]   cfg_depth;
  logic [DEC_W-1:0]  cfg_dec;
  logic [CW_W-1:0]   cfg_cw;

  tbu_cfg_decode #(.KS_W(KS_W), .DP_W(DP_W), .DC_W(DEC_W), .CWD_W(CW_W)) cfg_i (
    .ks        (k_sel),
    .depth_req (tb_depth),
    .depth_eff (cfg_depth),
    .dec_cnt   (cfg_dec),
    .cw        (cfg_cw)
  );

  tbu_state_e        state_q;
  logic [KS_W-1:0]   ksel_q;
  logic [DP_W-1:0]   depth_q;
  logic [CW_W-1:0]   cw_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [RIDX_W-1:0] cur_ridx_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_q;

  // named events used by the control and by the checker
  logic              start_take;
  logic              at_last;
  logic              rd_fire;
  logic              step_fire;
  logic              push_en;
  logic              pop_en;
  logic              surv_bit;
  logic [ADDR_W-1:0] nxt_addr;
  logic [RIDX_W-1:0] nxt_ridx;
  logic              lifo_top;
  logic [LCNT_W-1:0] lifo_cnt;

  assign start_take = start && (state_q == ST_IDLE);
  assign at_last    = (step_q == last_q);
  assign rd_fire    = (state_q == ST_READ) && !at_last;
  assign step_fire  = (state_q == ST_UPD);
  assign push_en    = (state_q == ST_READ) && (step_q >= STEP_W'(depth_q));
  assign pop_en     = (state_q == ST_EMIT) && (lifo_cnt != '0);

  tbu_step_unit #(.A_W(ADDR_W), .D_W(DATA_W), .R_W(RIDX_W), .C_W(CW_W)) step_i (
    .cur_addr (cur_addr_q),
    .cur_ridx (cur_ridx_q),
    .word     (mem_rd_data),
    .cw       (cw_q),
    .surv_bit (surv_bit),
    .nxt_addr (nxt_addr),
    .nxt_ridx (nxt_ridx)
  );

  tbu_lifo #(.DEPTH(OUT_MAX), .CNT_W(LCNT_W)) lifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_en),
    .pop   (pop_en),
    .din   (cur_ridx_q[0]),
    .dout  (lifo_top),
    .count (lifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ksel_q     <= '0;
      depth_q    <= '0;
      cw_q       <= CW_W'(CW_MIN);
      cur_addr_q <= '0;
      cur_ridx_q <= '0;
      step_q     <= '0;
      last_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            state_q    <= ST_READ;
            ksel_q     <= k_sel;
            depth_q    <= cfg_depth;
            cw_q       <= cfg_cw;
            cur_addr_q <= start_addr;
            cur_ridx_q <= start_ridx;
            step_q     <= '0;
            last_q     <= STEP_W'(cfg_depth) + STEP_W'(cfg_dec) - STEP_W'(1);
          end
        end
        ST_READ: begin
          state_q <= at_last ? ST_EMIT : ST_UPD;
        end
        ST_UPD: begin
          cur_addr_q <= nxt_addr;
          cur_ridx_q <= nxt_ridx;
          step_q     <= step_q + STEP_W'(1);
          state_q    <= ST_READ;
        end
        default: begin
          if (lifo_cnt <= LCNT_W'(1))
            state_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= pop_en;
      dec_bit   <= pop_en ? lifo_top : 1'b0;
    end
  end

  assign mem_rd_en   = rd_fire;
  assign mem_rd_addr = cur_addr_q;

endmodule

// File: rtl/tbu_checker.sv
module tbu_checker
  import tbu_pkg::*;
#(
  parameter int unsigned A_W    = SM_ADDR_W,
  parameter int unsigned KS_W   = KSEL_W,
  parameter int unsigned DP_W   = DEPTH_W,
  parameter int unsigned LIFO_D = DEC_MAX,
  parameter int unsigned LC_W   = $clog2(DEC_MAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_rd_en,
  input logic            dec_valid,
  input logic            step_fire,
  input logic            push_en,
  input logic [LC_W-1:0] lifo_cnt,
  input logic [A_W-1:0]  cur_addr,
  input logic [CW_W-1:0] cw_q,
  input logic [KS_W-1:0] ksel_q,
  input logic [DP_W-1:0] depth_q
);

  function automatic logic iter_went_down(input logic [A_W-1:0]  now_a,
                                          input logic [A_W-1:0]  was_a,
                                          input logic [CW_W-1:0] w);
    logic [A_W-1:0] in_now;
    logic [A_W-1:0] in_was;
    logic [A_W-1:0] imask;
    in_now = now_a >> w;
    in_was = was_a >> w;
    imask  = {A_W{1'b1}} >> w;
    return ((in_now + A_W'(1)) & imask) == in_was;
  endfunction

  function automatic logic [DP_W-1:0] depth_limit(input logic [KS_W-1:0] ks);
    logic [DP_W-1:0] v;
    case (ks)
      2'd0:    v = DP_W'(49);
      2'd1:    v = DP_W'(57);
      2'd2:    v = DP_W'(61);
      default: v = DP_W'(62);
    endcase
    return v;
  endfunction

  p_read_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_iter_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> iter_went_down(cur_addr, $past(cur_addr), cw_q));

  p_quiet_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !dec_valid);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (lifo_cnt < LC_W'(LIFO_D)));

  p_depth_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (depth_q <= depth_limit(ksel_q)));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> $stable(cw_q));

endmodule

bind cfg_traceback_unit tbu_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd_en (mem_rd_en),
  .dec_valid (dec_valid),
  .step_fire (step_fire),
  .push_en   (push_en),
  .lifo_cnt  (lifo_cnt),
  .cur_addr  (cur_addr_q),
  .cw_q      (cw_q),
  .ksel_q    (ksel_q),
  .depth_q   (depth_q)
);

// File: tb/cfg_traceback_unit_tb_top.sv
module cfg_traceback_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  k_sel = '0;
  logic [5:0]  tb_depth = '0;
  logic        start = 1'b0;
  logic [11:0] start_addr = '0;
  logic [2:0]  start_ridx = '0;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        dec_bit;
  logic        dec_valid;

  logic [7:0]  smem [4096];

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cfg_traceback_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .k_sel       (k_sel),
    .tb_depth    (tb_depth),
    .start       (start),
    .start_addr  (start_addr),
    .start_ridx  (start_ridx),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .dec_bit     (dec_bit),
    .dec_valid   (dec_valid)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= smem[mem_rd_addr];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int depth_cap(input int ks);
    case (ks)
      0: return 49;
      1: return 57;
      2: return 61;
      default: return 62;
    endcase
  endfunction

  // state number -> (cycle field, bit index), built bit by bit from the R3 rule
  task automatic place(input int s, input int c, output int cf, output int rf);
    int m;
    int r0;
    int r1;
    int r2;
    m  = c + 3;
    cf = 0;
    for (int j = 0; j < c; j++) cf = cf | (((s >> (m - 3 - j)) & 1) << j);
    r1 = (s >> (m - 1)) & 1;
    r0 = s & 1;
    r2 = ((s >> (m - 2)) & 1) ^ ((cf >> (c - 1)) & 1);
    rf = (r2 << 2) | (r1 << 1) | r0;
  endtask

  task automatic run_case(input int ks, input int req, input int base, input bit restart,
                          input string extra);
    int c, m, d, te, nit, len, smask;
    int s [0:80];
    int got [0:31];
    int nbits, reads, first_addr, cf, rf, it, b2b, start_a, bad;
    bit prev_rd;
    c     = 3 + ks;
    m     = c + 3;
    d     = 16 >> ks;
    te    = (req > depth_cap(ks)) ? depth_cap(ks) : req;
    nit   = 1 << (12 - c);
    len   = te + d + 1;
    smask = (1 << m) - 1;
    s[0]  = int'($urandom) & smask;
    for (int t = 1; t < len; t++) s[t] = ((s[t-1] << 1) | int'($urandom & 1)) & smask;
    for (int a = 0; a < 4096; a++) smem[a] = 8'($urandom);
    for (int t = 1; t < len; t++) begin
      place(s[t], c, cf, rf);
      it = (base + t) % nit;
      smem[(it << c) | cf][rf] = 1'((s[t-1] >> (m - 1)) & 1);
    end
    place(s[len-1], c, cf, rf);
    start_a = (((base + len - 1) % nit) << c) | cf;
    @(negedge clk);
    k_sel      = 2'(ks);
    tb_depth   = 6'(req);
    start_addr = 12'(start_a);
    start_ridx = 3'(rf);
    start      = 1'b1;
    nbits = 0; reads = 0; first_addr = -1; b2b = 0; prev_rd = 1'b0;
    for (int cyc = 0; cyc < 2 * (te + d) + d + 20; cyc++) begin
      @(negedge clk);
      if (cyc == 0) start = 1'b0;
      if (restart && cyc == 3) begin
        start      = 1'b1;
        k_sel      = 2'(ks ^ 1);
        tb_depth   = 6'd3;
        start_addr = 12'($urandom);
        start_ridx = 3'($urandom);
      end
      if (restart && cyc == 4) start = 1'b0;
      if (mem_rd_en) begin
        if (first_addr < 0) first_addr = int'(mem_rd_addr);
        reads++;
        if (prev_rd) b2b++;
      end
      prev_rd = mem_rd_en;
      if (dec_valid) begin
        if (nbits < 32) got[nbits] = int'(dec_bit);
        nbits++;
      end
    end
    check(first_addr == start_a, {"R2 first read address ", extra}, first_addr, start_a);
    check(b2b == 0, {"R4 back-to-back reads ", extra}, b2b, 0);
    check(reads == te + d - 1, {"R6 read count ", extra}, reads, te + d - 1);
    if (req > depth_cap(ks))
      check(reads == depth_cap(ks) + d - 1, {"R7 clamped depth reads ", extra},
            reads, depth_cap(ks) + d - 1);
    check(nbits == d, {"R8 decoded bit count ", extra}, nbits, d);
    bad = 0;
    for (int i = 0; i < d && i < nbits; i++) begin
      // oldest first: output i holds the input bit of time i+1
      check(got[i] == (s[i+1] & 1), {"R3 decoded bit value ", extra}, got[i], s[i+1] & 1);
      if (got[i] != (s[i+1] & 1)) bad++;
    end
    if (restart) check(bad == 0 && nbits == d, {"R9 restart ignored ", extra}, bad, 0);
    if (base + len > nit) check(bad == 0, {"R5 wrapped walk ", extra}, bad, 0);
  endtask

  task automatic run_example();
    int addrs [0:3];
    int n;
    for (int a = 0; a < 4096; a++) smem[a] = 8'h00;
    smem[12'h02C] = 8'b0010_0000;
    @(negedge clk);
    k_sel = 2'd0; tb_depth = 6'd0; start_addr = 12'h02C; start_ridx = 3'b101; start = 1'b1;
    n = 0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      if (cyc == 0) start = 1'b0;
      if (mem_rd_en) begin
        if (n < 4) addrs[n] = int'(mem_rd_addr);
        n++;
      end
    end
    check(n >= 2 && addrs[0] == 'h02C, "R10 first read", addrs[0], 'h02C);
    check(n >= 2 && addrs[1] == 'h020, "R10 second read", addrs[1], 'h020);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    for (int a = 0; a < 4096; a++) smem[a] = 8'h00;
    start = 1'b1;
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0, "R1 dec_valid in reset", int'(dec_valid), 0);
    check(mem_rd_en == 1'b0, "R1 mem_rd_en in reset", int'(mem_rd_en), 0);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dec_valid == 1'b0 && mem_rd_en == 1'b0, "R1 idle after reset",
          int'(dec_valid) + int'(mem_rd_en), 0);

    run_example();
    run_case(0, 35, 7,   1'b0, "K7 depth35");
    run_case(1, 40, 100, 1'b0, "K8 depth40");
    run_case(2, 45, 20,  1'b0, "K9 depth45");
    run_case(3, 50, 3,   1'b0, "K10 depth50");
    run_case(3, 62, 40,  1'b0, "K10 wrap max");
    run_case(0, 30, 500, 1'b0, "K7 wrap");
    run_case(3, 63, 0,   1'b0, "K10 clamp");
    run_case(0, 63, 9,   1'b0, "K7 clamp");
    run_case(1, 60, 11,  1'b0, "K8 clamp");
    run_case(2, 63, 13,  1'b0, "K9 clamp");
    run_case(3, 0,  5,   1'b0, "K10 depth0");
    run_case(0, 0,  6,   1'b0, "K7 depth0");
    run_case(1, 20, 30,  1'b1, "K8 restart");
    run_case(0, 35, 44,  1'b1, "K7 restart");
    for (int i = 0; i < 12; i++) begin
      int ks;
      ks = int'($urandom % 4);
      run_case(ks, int'($urandom % 64), int'($urandom % 512), 1'b0, "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule